// File: doc/BRIEF.md
# Cascadable Parallel-to-Serial Shift Register

This block turns a parallel word into a serial bit stream. On an enabled clock it either captures a whole word from its parallel bus or moves every stored bit one position toward the output end. When it shifts, the position at the input end takes a fresh bit from a serial input. The bit in the last position is always on the serial output, so a captured word leaves most-significant position first, one bit per enabled clock.

Longer words are built by chaining stages. The serial output of one stage drives the serial input of the next, and all stages share the clock, the enable and the load select. The output of the last stage carries the whole chained word.

Clock gating is expressed as a synchronous hold. An active-low enable freezes the register on a single free-running clock, and an active-low asynchronous reset clears it. The interface is plain pins with no handshake. A consumer that cannot take a bit on some clock holds the enable high for that clock, and that is the only form of back-pressure.

Top module: `piso_shift_reg`

## Requirements
- R1: While `rst_n` is 0, every bit of `taps` is 0 without waiting for a clock edge, and `ser_out` reads 0 after release until the first load or shift.
- R2: On a rising edge with `clk_en_n`=0 and `load_n`=0, `taps[k]` takes `par_in[k]` for every k.
- R3: On a rising edge with `clk_en_n`=0 and `load_n`=1, `taps[0]` takes `ser_in` and `taps[k]` takes the old `taps[k-1]` for k from 1 to WIDTH-1.
- R4: On a rising edge with `clk_en_n`=1, `taps` keeps its value whatever `load_n`, `par_in` and `ser_in` are.
- R5: `ser_out` always equals `taps[WIDTH-1]`.
- R6: After a load, `ser_out` presents `par_in[WIDTH-1]` first, then `par_in[WIDTH-2]` down to `par_in[0]`, moving one bit per enabled shift edge. Hold cycles do not disturb this order.
- R7: When two stages are chained (first stage `ser_out` to second stage `ser_in`) and both are loaded together, the second stage's `ser_out` presents its own word (high bit first) and then the first stage's word (high bit first), 2*WIDTH bits in total.
- R8: A reset asserted in the middle of a stream wins over a load or shift requested at the same clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous clear, active low |
| clk_en_n | input | 1 | Clock enable, active low; high holds the register |
| load_n | input | 1 | 0 selects a parallel load, 1 selects a shift |
| par_in | input | WIDTH | Parallel word; bit k goes to position k |
| ser_in | input | 1 | Serial bit shifted into position 0 |
| ser_out | output | 1 | Last position, the serial output |
| taps | output | WIDTH | Whole register, exposed for test |

## Verification
The bench builds two stages with the default WIDTH of 8 and chains them. A single loaded pair therefore yields a 16-bit stream, which makes the cross-stage order of R7 observable. The narrow width lets randomly placed loads, holds and shifts frequently reach the boundaries: a load right before a shift runs out, a load or shift request held off mid-stream, and a reset landing partway through a word. Every cycle both registers are compared with a bench model of the chained pair.

// File: rtl/piso_pkg.sv
package piso_pkg;

  // Operation applied to every register position on an edge.
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_SHIFT = 2'd1,
    OP_LOAD  = 2'd2
  } piso_op_e;

endpackage

// File: rtl/piso_ctrl.sv
module piso_ctrl
  import piso_pkg::*;
(
  input  logic     clk_en_n,
  input  logic     load_n,
  output piso_op_e op
);

  // The enable gates both actions; load select only matters when enabled.
  always_comb begin
    if (clk_en_n)     op = OP_HOLD;
    else if (!load_n) op = OP_LOAD;
    else              op = OP_SHIFT;
  end

endmodule

// File: rtl/piso_cell.sv
module piso_cell
  import piso_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  piso_op_e op,
  input  logic     par_bit,
  input  logic     prev_bit,
  output logic     q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else begin
      case (op)
        OP_LOAD:  q <= par_bit;
        OP_SHIFT: q <= prev_bit;
        default:  q <= q;
      endcase
    end
  end

endmodule

// File: rtl/piso_shift_reg.sv
module piso_shift_reg
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] par_in,
  input  logic             ser_in,
  output logic             ser_out,
  output logic [WIDTH-1:0] taps
);

  localparam int LAST = WIDTH - 1;

  piso_op_e         op;
  logic [WIDTH-1:0] reg_q;

  piso_ctrl u_ctrl (
    .clk_en_n (clk_en_n),
    .load_n   (load_n),
    .op       (op)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_pos
    logic prev;
    if (i == 0) begin : g_head
      assign prev = ser_in;
    end else begin : g_body
      assign prev = reg_q[i-1];
    end
    piso_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (op),
      .par_bit  (par_in[i]),
      .prev_bit (prev),
      .q        (reg_q[i])
    );
  end

  assign taps    = reg_q;
  assign ser_out = reg_q[LAST];

  // R1 / R8: reset low means the register is clear at every edge it spans.
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (taps == '0));

  // R2: enabled load captures the bus position for position.
  p_load_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !load_n) |=> (taps == $past(par_in)));

  // R3: enabled shift moves toward the output and takes ser_in at position 0.
  p_shift_move_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && load_n) |=> (taps == {$past(taps[LAST-1:0]), $past(ser_in)}));

  // R4: disabled clock leaves the register untouched.
  p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> $stable(taps));

endmodule

// File: tb/piso_shift_reg_bench.sv
module piso_shift_reg_bench;

  localparam int W = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n = 1'b1;
  logic         en_n  = 1'b1;
  logic         ld_n  = 1'b1;
  logic         si    = 1'b0;
  logic [W-1:0] par_h = '0;
  logic [W-1:0] par_t = '0;
  logic [W-1:0] taps_h, taps_t;
  logic         out_h, out_t;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] m_h = '0;
  logic [W-1:0] m_t = '0;

  // First stage of the chain.
  piso_shift_reg #(.WIDTH(W)) u_head (
    .clk(clk), .rst_n(rst_n), .clk_en_n(en_n), .load_n(ld_n),
    .par_in(par_h), .ser_in(si), .ser_out(out_h), .taps(taps_h)
  );

  // Last stage of the chain; its ser_out is the chain output.
  piso_shift_reg #(.WIDTH(W)) u_piso_shift_reg (
    .clk(clk), .rst_n(rst_n), .clk_en_n(en_n), .load_n(ld_n),
    .par_in(par_t), .ser_in(out_h), .ser_out(out_t), .taps(taps_t)
  );

  function automatic logic [W-1:0] next_state(logic [W-1:0] cur, logic e,
                                              logic l, logic [W-1:0] p, logic s);
    if (e)  return cur;
    if (!l) return p;
    return {cur[W-2:0], s};
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk(req, taps_h, m_h);
    chk(req, taps_t, m_t);
    chk("R5 ser_out tracks last position", {{(W-1){1'b0}}, out_t}, {{(W-1){1'b0}}, m_t[W-1]});
    chk("R5 ser_out tracks last position", {{(W-1){1'b0}}, out_h}, {{(W-1){1'b0}}, m_h[W-1]});
  endtask

  // Drive at the falling edge, let one rising edge pass, check at the next falling edge.
  task automatic step(logic e, logic l, logic [W-1:0] ph, logic [W-1:0] pt, logic s);
    en_n = e; ld_n = l; par_h = ph; par_t = pt; si = s;
    @(posedge clk);
    m_t = next_state(m_t, e, l, pt, m_h[W-1]);
    m_h = next_state(m_h, e, l, ph, s);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected run completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] word_a, word_b;
    logic [2*W-1:0] got;
    int shifts;

    void'($urandom(32'd20240611));

    // Reset state (R1)
    #1 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 reset clears head", taps_h, '0);
    chk("R1 reset clears tail", taps_t, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ser_out low after release", {{(W-1){1'b0}}, out_t}, '0);

    // Directed load and shift (R2, R3)
    step(1'b0, 1'b0, 8'hA5, 8'h3C, 1'b0);
    chk_all("R2 parallel load");
    step(1'b0, 1'b1, 8'h00, 8'h00, 1'b1);
    chk_all("R3 shift with serial 1");
    step(1'b0, 1'b1, 8'hFF, 8'hFF, 1'b0);
    chk_all("R3 shift ignores par_in");

    // Hold with load requested and bus changing (R4)
    step(1'b1, 1'b0, 8'h5A, 8'hC3, 1'b1);
    chk_all("R4 hold ignores load");
    step(1'b1, 1'b1, 8'h11, 8'h22, 1'b1);
    chk_all("R4 hold ignores shift");

    // Chained 16-bit order with mid-stream holds (R6, R7)
    word_a = 8'b1101_0010;
    word_b = 8'b1011_0001;
    step(1'b0, 1'b0, word_a, word_b, 1'b0);
    got = '0;
    got = {got[2*W-2:0], out_t};
    shifts = 0;
    while (shifts < 2*W-1) begin
      if (shifts == 3 || shifts == 10) begin
        step(1'b1, 1'b0, 8'hFF, 8'h00, 1'b1);
        chk_all("R4 hold mid-stream");
      end
      step(1'b0, 1'b1, 8'h00, 8'hFF, 1'b0);
      got = {got[2*W-2:0], out_t};
      shifts++;
    end
    chk("R6 tail word high bit first", got[2*W-1:W], word_b);
    chk("R7 head word follows tail word", got[W-1:0], word_a);

    // Reset in the middle of shifting (R1, R8)
    step(1'b0, 1'b0, 8'hE7, 8'h7E, 1'b1);
    step(1'b0, 1'b1, 8'h00, 8'h00, 1'b1);
    step(1'b0, 1'b1, 8'h00, 8'h00, 1'b1);
    rst_n = 1'b0;
    #3;
    chk("R1 async clear before any edge", taps_t, '0);
    chk("R1 async clear head", taps_h, '0);
    @(negedge clk);
    en_n = 1'b0; ld_n = 1'b0; par_h = 8'hFF; par_t = 8'hFF;
    @(negedge clk);
    chk("R8 reset beats load", taps_h, '0);
    ld_n = 1'b1; si = 1'b1;
    @(negedge clk);
    chk("R8 reset beats shift", taps_t | taps_h, '0);
    m_h = '0; m_t = '0;
    en_n = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 state after mid-stream reset");

    // Constrained random mix of holds, loads and shifts
    for (int n = 0; n < 600; n++) begin
      logic e, l;
      e = ($urandom_range(0, 3) == 0);
      l = ($urandom_range(0, 6) != 0);
      step(e, l, W'($urandom), W'($urandom), 1'($urandom));
      if (e)       chk_all("R4 random hold");
      else if (!l) chk_all("R2 random load");
      else         chk_all("R3 random shift");
    end

    finish_run();
  end

endmodule